// File: doc/BRIEF.md
# Latched Interrupt Status Controller

The block gathers eight interrupt sources into sticky status bits and drives one level interrupt request line. Four sources come from digital input pins. Each pin is synchronized, then passed through an edge detector whose polarity and gating come from per-pin configuration inputs. The other four sources are internal. A FIFO overrun is a push that arrives while the FIFO is full. A FIFO almost-full event occurs when the FIFO fill count reaches a programmable threshold. The last two are a DMA timeout pulse and a DMA done pulse.

Software sees one 32-bit word. It holds the latched status bits, an enable for each source, and the watchdog timeout flag. A write clears every status bit written as 1 and loads the enables. Software can therefore read the word, handle the interrupts, and write the same value back. That write acknowledges everything it saw and leaves the enables unchanged. The FIFO, the DMA engine and the bus are outside the block; they appear only as pulses, a count and a write strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status bits and enable bits are zero and `irqOut` is low. `regRead` then shows only `wdogFlag` in bit 31.
- R2: The word on `regRead` has this layout:
  - bit 31 is `wdogFlag`;
  - bits 23:16 are status bits and bits 7:0 are the matching enables, in the same order from MSB down: external pin, DAC-load pin, FIFO overrun, FIFO almost-full, DMA timeout, DMA done, ADC-start pin, ADC-trigger pin;
  - all other bits read 0.
- R3: A cycle with `regWrEn` high does two things at the next clock edge:
  - it clears each status bit whose `regWrData` bit in 23:16 is 1;
  - it loads the enables from `regWrData[7:0]`.
  Writing back the word just read clears the seen interrupts and keeps the enables.
- R4: A source event sets its status bit only if that source's enable is 1 in the cycle of the event. An event on a disabled source leaves the status unchanged.
- R5: `irqOut` is high exactly when at least one status bit is 1.
- R6: Each pin `pinIn[i]` is synchronized by two flops and then edge-detected. The pin order is [3] external, [2] DAC-load, [1] ADC-start, [0] ADC-trigger.
  - `pinRise[i]`=1 selects rising edges and 0 selects falling edges.
  - `pinFnEn[i]`=0 suppresses detection on that pin.
  - A pin change first sampled at clock edge k sets its status bit at edge k+2.
- R7: The almost-full event fires once for each crossing of `fifoLevel >= afThreshold` from false to true. While the condition stays true it does not fire again, even after its status bit is cleared.
- R8: A cycle with `fifoPush` and `fifoFull` both high is an overrun event; it sets the status at the next edge.
- R9: A one-cycle pulse on `dmaTimeout` or `dmaDone` sets its status at the next edge.
- R10: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A status bit stays set until a write clears it or reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Asynchronous digital source pins |
| pinRise | input | 4 | Edge polarity per pin, 1 = rising |
| pinFnEn | input | 4 | Detection enable per pin |
| fifoLevel | input | 12 | FIFO fill count |
| afThreshold | input | 12 | Almost-full threshold |
| fifoPush | input | 1 | FIFO write strobe |
| fifoFull | input | 1 | FIFO full flag |
| dmaTimeout | input | 1 | DMA timeout pulse |
| dmaDone | input | 1 | DMA done pulse |
| wdogFlag | input | 1 | Watchdog timeout flag |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRead | output | 32 | Register read word |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench goes after five corner cases:
- **Set and clear in the same cycle.** A design where the clear wins would silently drop the interrupt.
- **Almost-full condition held true across a clear.** A level-sensitive design would latch the bit again at once.
- **Falling-edge selection.** A design with the polarity wrong would fire when the pin rises.
- **Events on disabled sources, or on pins whose detection is off.** A leaky design would raise the interrupt line.
- **Write-back of a read value.** A design that loaded enables incorrectly would lose its enables on acknowledge.

The pin latency of exactly two synchronizer stages is checked cycle by cycle against the reference model.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC = 8;
  localparam int NUM_PIN = 4;
  // source bit positions inside the status/enable byte
  localparam int SRC_EXT      = 7;
  localparam int SRC_DACLOAD  = 6;
  localparam int SRC_OVERRUN  = 5;
  localparam int SRC_ALMOST   = 4;
  localparam int SRC_DMATO    = 3;
  localparam int SRC_DMADONE  = 2;
  localparam int SRC_ADCSTART = 1;
  localparam int SRC_ADCTRIG  = 0;
  // word layout
  localparam int WORD_W     = 32;
  localparam int STATUS_LSB = 16;
  localparam int ENABLE_LSB = 0;
  localparam int WDOG_BIT   = 31;

  typedef struct packed {
    logic [NUM_SRC-1:0] evt;
    logic               wrStb;
    logic [NUM_SRC-1:0] clrMask;
    logic [NUM_SRC-1:0] enLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  input  logic riseSel,
  input  logic fnEn,
  output logic edgePulse
);
  logic syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pinAsync;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_comb begin
    if (riseSel) edgePulse = fnEn & syncB & ~prevB;
    else         edgePulse = fnEn & ~syncB & prevB;
  end
endmodule

// File: rtl/irq_status_ctrl_unit.sv
module irq_status_ctrl_unit
  import irq_status_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIN-1:0] pinIn,
  input  logic [NUM_PIN-1:0] pinRise,
  input  logic [NUM_PIN-1:0] pinFnEn,
  input  logic [CNT_W-1:0]   fifoLevel,
  input  logic [CNT_W-1:0]   afThreshold,
  input  logic               fifoPush,
  input  logic               fifoFull,
  input  logic               dmaTimeout,
  input  logic               dmaDone,
  input  logic               regWrEn,
  input  logic [WORD_W-1:0]  regWrData,
  output ctrlStrobes_t       strobes
);
  logic [NUM_PIN-1:0] pinPulse;
  logic afNow, afPrev, afStrobe;

  for (genvar i = 0; i < NUM_PIN; i++) begin : gPin
    irq_pin_edge uEdge (
      .clk(clk), .rstN(rstN), .pinAsync(pinIn[i]),
      .riseSel(pinRise[i]), .fnEn(pinFnEn[i]), .edgePulse(pinPulse[i])
    );
  end

  assign afNow = (fifoLevel >= afThreshold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) afPrev <= 1'b0;
    else       afPrev <= afNow;
  end

  assign afStrobe = afNow & ~afPrev;

  always_comb begin
    strobes = '0;
    strobes.evt[SRC_EXT]      = pinPulse[3];
    strobes.evt[SRC_DACLOAD]  = pinPulse[2];
    strobes.evt[SRC_ADCSTART] = pinPulse[1];
    strobes.evt[SRC_ADCTRIG]  = pinPulse[0];
    strobes.evt[SRC_OVERRUN]  = fifoPush & fifoFull;
    strobes.evt[SRC_ALMOST]   = afStrobe;
    strobes.evt[SRC_DMATO]    = dmaTimeout;
    strobes.evt[SRC_DMADONE]  = dmaDone;
    strobes.wrStb   = regWrEn;
    strobes.clrMask = regWrEn ? regWrData[STATUS_LSB +: NUM_SRC] : '0;
    strobes.enLoad  = regWrData[ENABLE_LSB +: NUM_SRC];
  end

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // almost-full fires once per crossing, never two cycles in a row
  assert_af_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evt[SRC_ALMOST] |=> !strobes.evt[SRC_ALMOST]);

  // an almost-full strobe needs the condition false one cycle earlier
  assert_af_crossing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strobes.evt[SRC_ALMOST]) |->
      ($past(fifoLevel) < $past(afThreshold) || !$past(pastValid)));
endmodule

// File: rtl/irq_status_data.sv
module irq_status_data
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               wdogFlag,
  output logic [WORD_W-1:0]  regRead,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] statusQ, enableQ, statusD, setMask;

  assign setMask = strobes.evt & enableQ;
  assign statusD = (statusQ & ~strobes.clrMask) | setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusD;
      if (strobes.wrStb) enableQ <= strobes.enLoad;
    end
  end

  always_comb begin
    regRead = '0;
    regRead[WDOG_BIT] = wdogFlag;
    regRead[STATUS_LSB +: NUM_SRC] = statusQ;
    regRead[ENABLE_LSB +: NUM_SRC] = enableQ;
  end

  assign irqOut = |statusQ;

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // newly set bits must come from an enabled event
  assert_latch_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((statusQ & ~$past(statusQ) & ~($past(strobes.evt) & $past(enableQ))) == '0));

  // without a write nothing drops
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobes.wrStb)) |-> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // set beats clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((($past(strobes.evt) & $past(enableQ)) & ~statusQ) == '0));

  // written ones clear unless an event collides
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.wrStb)) |->
      ((statusQ & $past(strobes.clrMask) & ~($past(strobes.evt) & $past(enableQ))) == '0));

  // request can only drop after a write
  assert_irq_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(irqOut)) |-> $past(strobes.wrStb));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        pinIn,
  input  logic [3:0]        pinRise,
  input  logic [3:0]        pinFnEn,
  input  logic [CNT_W-1:0]  fifoLevel,
  input  logic [CNT_W-1:0]  afThreshold,
  input  logic              fifoPush,
  input  logic              fifoFull,
  input  logic              dmaTimeout,
  input  logic              dmaDone,
  input  logic              wdogFlag,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRead,
  output logic              irqOut
);
  ctrlStrobes_t strobes;

  irq_status_ctrl_unit #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinRise(pinRise), .pinFnEn(pinFnEn),
    .fifoLevel(fifoLevel), .afThreshold(afThreshold), .fifoPush(fifoPush),
    .fifoFull(fifoFull), .dmaTimeout(dmaTimeout), .dmaDone(dmaDone),
    .regWrEn(regWrEn), .regWrData(regWrData), .strobes(strobes)
  );

  irq_status_data uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdogFlag(wdogFlag),
    .regRead(regRead), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic clk = 0, rstN = 0;
  logic [3:0] pinIn = 0, pinRise = 4'hF, pinFnEn = 0;
  logic [11:0] fifoLevel = 0, afThreshold = 12'd100;
  logic fifoPush = 0, fifoFull = 0, dmaTimeout = 0, dmaDone = 0, wdogFlag = 0;
  logic regWrEn = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRead;
  logic irqOut;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_ctrl dut (.*);

  // reference model state
  bit [3:0] pinHist[$];
  bit [3:0] syncd = 0, lastSyncd = 0;
  bit afWas = 0;
  bit [7:0] mStatus = 0, mEnable = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      pinHist = {}; syncd = 0; lastSyncd = 0; afWas = 0; mStatus = 0; mEnable = 0;
    end else begin
      bit [7:0] ev;
      bit [3:0] hit;
      bit afIs;
      for (int i = 0; i < 4; i++)
        hit[i] = pinFnEn[i] && (pinRise[i] ? (syncd[i] && !lastSyncd[i]) : (!syncd[i] && lastSyncd[i]));
      afIs = (fifoLevel >= afThreshold);
      ev = {hit[3], hit[2], fifoPush && fifoFull, afIs && !afWas, dmaTimeout, dmaDone, hit[1], hit[0]};
      afWas = afIs;
      lastSyncd = syncd;
      pinHist.push_back(pinIn);
      syncd = (pinHist.size() >= 2) ? pinHist[pinHist.size()-2] : 4'h0;
      if (pinHist.size() > 4) void'(pinHist.pop_front());
      if (regWrEn) mStatus = mStatus & ~regWrData[23:16];
      mStatus = mStatus | (ev & mEnable);
      if (regWrEn) mEnable = regWrData[7:0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every cycle comparison against the model (R2 layout, R5 request)
  always @(negedge clk) if (rstN && !done) begin
    chk("R2", regRead, {wdogFlag, 7'b0, mStatus, 8'b0, mEnable});
    chk("R5", {31'b0, irqOut}, {31'b0, |mStatus});
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [31:0] d);
    regWrEn = 1; regWrData = d; cyc(1); regWrEn = 0; regWrData = 0;
  endtask

  initial begin
    cyc(1);
    chk("R1", regRead, 32'h0);
    chk("R1", {31'b0, irqOut}, 32'h0);
    rstN = 1;
    cyc(1);
    chk("R1", regRead, 32'h0);
    wdogFlag = 1; cyc(1);
    chk("R2", regRead, 32'h8000_0000); wdogFlag = 0;

    // R4: disabled dma done ignored
    dmaDone = 1; cyc(1); dmaDone = 0;
    chk("R4", regRead, 32'h0);

    // R9: enable dma bits
    wr(32'h0000_000C);
    dmaDone = 1; cyc(1); dmaDone = 0;
    chk("R9", regRead, 32'h0004_000C);
    dmaTimeout = 1; cyc(1); dmaTimeout = 0;
    chk("R9", regRead, 32'h000C_000C);
    cyc(5);
    chk("R11", regRead, 32'h000C_000C);
    // R3: write back read value
    wr(regRead);
    chk("R3", regRead, 32'h0000_000C);
    chk("R5", {31'b0, irqOut}, 32'h0);

    // R8: overrun
    wr(32'h0000_0020);
    fifoFull = 1; cyc(1);
    chk("R8", regRead, 32'h0000_0020);
    fifoPush = 1; cyc(1); fifoPush = 0; fifoFull = 0;
    chk("R8", regRead, 32'h0020_0020);

    // R10: collide clear with new overrun
    fifoFull = 1; fifoPush = 1;
    regWrEn = 1; regWrData = 32'h0020_0020; cyc(1);
    regWrEn = 0; regWrData = 0; fifoFull = 0; fifoPush = 0;
    chk("R10", regRead, 32'h0020_0020);
    wr(32'h0020_0000);
    chk("R3", regRead, 32'h0);

    // R7: almost full crossing
    wr(32'h0000_0010);
    fifoLevel = 99; cyc(1);
    chk("R7", regRead, 32'h0000_0010);
    fifoLevel = 100; cyc(1);
    chk("R7", regRead, 32'h0010_0010);
    wr(32'h0010_0010);
    fifoLevel = 120; cyc(3);
    chk("R7", regRead, 32'h0000_0010);
    fifoLevel = 10; cyc(1); fifoLevel = 200; cyc(1);
    chk("R7", regRead, 32'h0010_0010);
    wr(32'h0010_0000); fifoLevel = 0; cyc(1);

    // R6: rising on external pin
    wr(32'h0000_0080); pinFnEn = 4'hF;
    pinIn[3] = 1; cyc(2);
    chk("R6", regRead, 32'h0000_0080);
    cyc(1);
    chk("R6", regRead, 32'h0080_0080);
    wr(32'h0080_0080);
    pinIn[3] = 0; cyc(4);
    chk("R6", regRead, 32'h0000_0080);
    // falling select on adc trigger
    wr(32'h0000_0001); pinRise[0] = 0;
    pinIn[0] = 1; cyc(4);
    chk("R6", regRead, 32'h0000_0001);
    pinIn[0] = 0; cyc(3);
    chk("R6", regRead, 32'h0001_0001);
    wr(32'h0001_0001);
    // detection disabled on adc start
    wr(32'h0000_0002); pinFnEn[1] = 0;
    pinIn[1] = 1; cyc(4); pinIn[1] = 0; cyc(4);
    chk("R6", regRead, 32'h0000_0002);
    pinFnEn[1] = 1; pinIn[1] = 1; cyc(3);
    chk("R6", regRead, 32'h0002_0002);
    // R4: dac pin disabled
    pinIn[2] = 1; cyc(4);
    chk("R4", regRead & 32'h0040_0000, 32'h0);

    // R1: reset mid-run
    rstN = 0; cyc(1);
    chk("R1", regRead, 32'h0);
    rstN = 1; pinIn = 0; cyc(2);
    chk("R1", {31'b0, irqOut}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule